// File: doc/BRIEF.md
# Presettable cascadable up/down counter

A synchronous binary counter, four bits wide by default, that moves up or down by one on each rising clock edge when enabled. It can be preset synchronously from a parallel data input. All state bits update together on the clock edge, so the outputs never ripple.

Two active-low count enables gate counting. One of them, the carry-in enable, also feeds forward combinationally into an active-low terminal-count output. That output goes low when the carry-in enable is low and the counter sits at its end value for the current direction: all ones when counting up, zero when counting down. Driving each stage's carry-in enable from the previous stage's terminal count builds a wider synchronous counter with no extra gating. All stages share the clock, the load and the direction. The block has no reset, so a user loads a known value before relying on the count.

Top module: `updown_cnt`

## Requirements
- R1: While `load_ni` is 0, the next rising edge loads `data_i` into `q_o`, whatever the values of `cep_ni`, `cet_ni` and `up_i`. Load wins over counting, so the counter does not also step in that cycle.
- R2: While `load_ni` is 1, `cep_ni` is 0, `cet_ni` is 0 and `up_i` is 1, each rising edge increments `q_o` by one modulo 2^WIDTH, so the maximum value is followed by 0.
- R3: Under the same enables with `up_i` at 0, each rising edge decrements `q_o` by one modulo 2^WIDTH, so 0 is followed by the maximum value.
- R4: While `load_ni` is 1 and either `cep_ni` or `cet_ni` is 1, `q_o` holds its value across the edge.
- R5: `tc_no` is 0 exactly when `cet_ni` is 0 and either `up_i` is 1 with `q_o` all ones, or `up_i` is 0 with `q_o` zero. In every other case it is 1. It follows `cet_ni`, `up_i` and `q_o` combinationally, with no clock edge.
- R6: `cep_ni` has no effect on `tc_no`.
- R7: Three stages form one 12-bit up/down counter when they share clock, load, direction and `cep_ni`, and each `tc_no` drives the next stage's `cet_ni`. The chain carries and borrows correctly across both the stage boundaries and the 12-bit wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| load_ni | input | 1 | Synchronous parallel load, active low |
| data_i | input | WIDTH | Preset value |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| cep_ni | input | 1 | Count enable, active low, local to this stage |
| cet_ni | input | 1 | Count enable, active low, also gates `tc_no` |
| q_o | output | WIDTH | Counter value |
| tc_no | output | 1 | Terminal count, active low |

## Verification
The bench loads every start value and applies every combination of direction and enables. It exposes three kinds of fault this way:
- a design that lets counting add to a load;
- a design that counts with only one enable low;
- a design that fails to wrap at the maximum value or at zero.

Terminal count is swept over every value, direction and enable setting before any clock edge. This catches a TC that ignores the direction, one that waits for a clock, and one that reacts to the local enable. A three-stage chain is loaded just below carry and borrow boundaries and at the 12-bit limits, then stepped through them. A stage that mishandles its carry-in would skip or repeat a 4-bit digit there.

// File: rtl/cnt_pkg.sv
`timescale 1ns/1ps
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_LOAD = 2'd1,
    MODE_INC  = 2'd2,
    MODE_DEC  = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
`timescale 1ns/1ps
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic      load_ni,
  input  logic      cep_ni,
  input  logic      cet_ni,
  input  logic      up_i,
  output cnt_mode_e mode_o
);
  always_comb begin
    if (!load_ni)                mode_o = MODE_LOAD;
    else if (cep_ni || cet_ni)   mode_o = MODE_HOLD;
    else if (up_i)               mode_o = MODE_INC;
    else                         mode_o = MODE_DEC;
  end
endmodule

// File: rtl/cnt_next.sv
`timescale 1ns/1ps
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_mode_e         mode_i,
  input  logic [WIDTH-1:0]  q_i,
  input  logic [WIDTH-1:0]  data_i,
  output logic [WIDTH-1:0]  q_nxt_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (mode_i)
      MODE_LOAD: q_nxt_o = data_i;
      MODE_INC:  q_nxt_o = q_i + ONE;
      MODE_DEC:  q_nxt_o = q_i - ONE;
      default:   q_nxt_o = q_i;
    endcase
  end
endmodule

// File: rtl/cnt_tc_gen.sv
`timescale 1ns/1ps
module cnt_tc_gen #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             up_i,
  input  logic             cet_ni,
  output logic             tc_no
);
  logic at_max, at_min;

  assign at_max = &q_i;
  assign at_min = ~|q_i;
  // carry-in feeds straight through so chains stay one gate per stage
  assign tc_no  = cet_ni | (up_i ? ~at_max : ~at_min);
endmodule

// File: rtl/updown_cnt.sv
`timescale 1ns/1ps
module updown_cnt
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_i,
  input  logic             cep_ni,
  input  logic             cet_ni,
  output logic [WIDTH-1:0] q_o,
  output logic             tc_no
);
  localparam logic [WIDTH-1:0] ONE   = WIDTH'(1);
  localparam logic [WIDTH-1:0] Q_MAX = {WIDTH{1'b1}};

  cnt_mode_e        mode;
  logic [WIDTH-1:0] q_q, q_nxt;

  cnt_mode_dec u_dec (
    .load_ni (load_ni),
    .cep_ni  (cep_ni),
    .cet_ni  (cet_ni),
    .up_i    (up_i),
    .mode_o  (mode)
  );

  cnt_next #(.WIDTH(WIDTH)) u_nxt (
    .mode_i  (mode),
    .q_i     (q_q),
    .data_i  (data_i),
    .q_nxt_o (q_nxt)
  );

  // no reset: value is defined by the first load
  always_ff @(posedge clk_i) q_q <= q_nxt;

  assign q_o = q_q;

  cnt_tc_gen #(.WIDTH(WIDTH)) u_tc (
    .q_i    (q_q),
    .up_i   (up_i),
    .cet_ni (cet_ni),
    .tc_no  (tc_no)
  );

  // checker arming: no history before the first edge
  logic chk_armed = 1'b0;
  always_ff @(posedge clk_i) chk_armed <= 1'b1;

  // R1
  load_chk: assert property (@(posedge clk_i) disable iff (!chk_armed)
    !load_ni |=> q_o == $past(data_i));
  // R2
  inc_chk: assert property (@(posedge clk_i) disable iff (!chk_armed)
    (load_ni && !cep_ni && !cet_ni && up_i) |=> q_o == $past(q_o) + ONE);
  // R3
  dec_chk: assert property (@(posedge clk_i) disable iff (!chk_armed)
    (load_ni && !cep_ni && !cet_ni && !up_i) |=> q_o == $past(q_o) - ONE);
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!chk_armed)
    (load_ni && (cep_ni || cet_ni)) |=> $stable(q_o));
  // R5
  tc_end_chk: assert property (@(posedge clk_i) disable iff (!chk_armed)
    !tc_no |-> (!cet_ni && q_o == (up_i ? Q_MAX : '0)));
  // R5
  tc_gate_chk: assert property (@(posedge clk_i) disable iff (!chk_armed)
    cet_ni |-> tc_no);
endmodule

// File: tb/tb_updown_cnt.sv
`timescale 1ns/1ps
module tb_updown_cnt;
  localparam int W = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // single stage
  logic         load_n = 1'b0, up = 1'b1, cep_n = 1'b1, cet_n = 1'b1;
  logic [W-1:0] d = '0, q;
  logic         tc_n;

  updown_cnt #(.WIDTH(W)) dut (
    .clk_i(clk), .load_ni(load_n), .data_i(d), .up_i(up),
    .cep_ni(cep_n), .cet_ni(cet_n), .q_o(q), .tc_no(tc_n)
  );

  // three-stage chain
  logic        c_load_n = 1'b0, c_up = 1'b1, c_cep_n = 1'b0, c_cet_n = 1'b1;
  logic [11:0] c_d = '0, c_q;
  logic [2:0]  c_tc_n;

  updown_cnt #(.WIDTH(4)) u_st0 (
    .clk_i(clk), .load_ni(c_load_n), .data_i(c_d[3:0]), .up_i(c_up),
    .cep_ni(c_cep_n), .cet_ni(c_cet_n), .q_o(c_q[3:0]), .tc_no(c_tc_n[0]));
  updown_cnt #(.WIDTH(4)) u_st1 (
    .clk_i(clk), .load_ni(c_load_n), .data_i(c_d[7:4]), .up_i(c_up),
    .cep_ni(c_cep_n), .cet_ni(c_tc_n[0]), .q_o(c_q[7:4]), .tc_no(c_tc_n[1]));
  updown_cnt #(.WIDTH(4)) u_st2 (
    .clk_i(clk), .load_ni(c_load_n), .data_i(c_d[11:8]), .up_i(c_up),
    .cep_ni(c_cep_n), .cet_ni(c_tc_n[1]), .q_o(c_q[11:8]), .tc_no(c_tc_n[2]));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(logic ld, logic [W-1:0] dv, logic u, logic p, logic t);
    @(negedge clk);
    load_n = ld; d = dv; up = u; cep_n = p; cet_n = t;
    @(posedge clk);
    #2;
  endtask

  task automatic ccyc(logic ld, logic [11:0] dv, logic u, logic t);
    @(negedge clk);
    c_load_n = ld; c_d = dv; c_up = u; c_cet_n = t;
    @(posedge clk);
    #2;
  endtask

  initial begin
    // first load defines the state (no reset)
    cyc(1'b0, 4'd9, 1'b1, 1'b1, 1'b1);
    check("R1 initial load", q, 9);

    // exhaustive start value x direction x enables
    for (int v = 0; v < 16; v++) begin
      for (int m = 0; m < 8; m++) begin
        logic u, p, t;
        int exp;
        u = m[2]; p = m[1]; t = m[0];
        cyc(1'b0, 4'(v), 1'b0, 1'b1, 1'b1);
        check("R1 load", q, v);
        cyc(1'b1, ~4'(v), u, p, t);
        if (p || t)   exp = v;
        else if (u)   exp = (v + 1) % 16;
        else          exp = (v + 15) % 16;
        if (p || t)   check("R4 hold", q, exp);
        else if (u)   check("R2 increment", q, exp);
        else          check("R3 decrement", q, exp);
        // load with count enabled must not also step
        cyc(1'b0, 4'(15 - v), u, 1'b0, 1'b0);
        check("R1 load priority", q, 15 - v);
      end
    end

    // terminal count sweep, held by load so no edge moves q
    for (int v = 0; v < 16; v++) begin
      for (int m = 0; m < 4; m++) begin
        logic u, t;
        int exp, tc_p0;
        u = m[1]; t = m[0];
        cyc(1'b0, 4'(v), 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        up = u; cet_n = t; cep_n = 1'b0;
        #1;
        exp = (!t && (u ? v == 15 : v == 0)) ? 0 : 1;
        check("R5 terminal count", tc_n, exp);
        tc_p0 = tc_n;
        cep_n = 1'b1;
        #1;
        check("R6 cep ignored by tc", tc_n, tc_p0);
      end
    end

    // example sequence through both wraps
    cyc(1'b0, 4'd13, 1'b1, 1'b1, 1'b1);
    check("R1 load 13", q, 13);
    begin
      int seq_up[5] = '{14, 15, 0, 1, 2};
      int seq_dn[5] = '{1, 0, 15, 14, 13};
      foreach (seq_up[i]) begin
        cyc(1'b1, 4'd0, 1'b1, 1'b0, 1'b0);
        check("R2 up sequence", q, seq_up[i]);
      end
      cyc(1'b1, 4'd0, 1'b1, 1'b1, 1'b0);
      check("R4 inhibit", q, 2);
      foreach (seq_dn[i]) begin
        cyc(1'b1, 4'd0, 1'b0, 1'b0, 1'b0);
        check("R3 down sequence", q, seq_dn[i]);
      end
    end

    // cascade across carry and borrow boundaries
    begin
      int starts[6] = '{12'h0FC, 12'hFFC, 12'h00E, 12'h103, 12'h003, 12'hF02};
      int dirs[6]   = '{1, 1, 1, 0, 0, 0};
      foreach (starts[i]) begin
        int exp;
        ccyc(1'b0, 12'(starts[i]), 1'(dirs[i]), 1'b1);
        check("R7 chain load", c_q, starts[i]);
        exp = starts[i];
        for (int k = 0; k < 8; k++) begin
          ccyc(1'b1, 12'd0, 1'(dirs[i]), 1'b0);
          exp = dirs[i] ? (exp + 1) % 4096 : (exp + 4095) % 4096;
          check("R7 chain count", c_q, exp);
        end
        ccyc(1'b1, 12'd0, 1'(dirs[i]), 1'b1);
        check("R7 chain hold", c_q, exp);
      end
      // top-stage terminal count at full 12-bit limit
      ccyc(1'b0, 12'hFFF, 1'b1, 1'b1);
      @(negedge clk);
      c_load_n = 1'b1; c_cet_n = 1'b0;
      #1;
      check("R7 chain terminal count", c_tc_n[2], 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule